// File: doc/BRIEF.md
# Three-Level Interrupt Arbiter with Round-Robin Low Level

This block decides which interrupt request is handed to the processor next. Every source carries a two-bit level code: none, low, medium or high. A request is counted only when four things are true: the source is raised, its own enable is set, the global enable is set, and its level is unmasked. Among the counted requests, the highest level wins. Inside the medium and high levels, the source with the lowest index wins. The low level can use the same fixed order. It can also use a rotating order, where the source acknowledged most recently at that level drops to the back of the queue.

The chosen vector goes out on a valid/ready interface. The processor takes it by raising `vec_ready` while `vec_valid` is high. Once `vec_valid` is up, the index and the level stay frozen until that acceptance happens, whatever the requests do in the meantime. Back-pressure is unlimited: the presented vector simply waits. The block keeps one executing flag per level, so handlers of different levels can nest. A vector is presented only when its level is strictly above every level that is executing. The `reti` strobe marks the end of a handler and clears the highest executing flag.

Top module: `irq_tri_arb`

## Requirements
- R1: Source i takes its level from `lvl_cfg[2i+1:2i]`, with 00 meaning none, 01 low, 10 medium and 11 high. When eligible requests sit at several levels, the one at the highest level is presented.
- R2: Among eligible requests of the same level, the lowest source index is presented. Medium and high always use this order. Low uses it while `rr_low` is 0.
- R3: While `rr_low` is 1, the low-level search starts at the index just above the last acknowledged low-level source and wraps around. That pointer resets to N-1. It is updated on every low-level acknowledge in either mode.
- R4: Source i is eligible only when all of these are set: `irq_req[i]`, `irq_en[i]`, `glb_en`, a non-zero level code, and the matching level mask bit (`lvl_en[0]` low, `[1]` medium, `[2]` high). Otherwise no vector is presented for it.
- R5: A vector is presented only if its level is strictly above the highest level flagged in `exec_status`. If no request qualifies, `vec_valid` stays 0.
- R6: While `vec_valid` is 1 and `vec_ready` is 0, `vec_valid`, `vec_idx` and `vec_lvl` hold their values, even if the requests change.
- R7: An acceptance (`vec_valid` and `vec_ready` both 1 at a clock edge) does three things. It sets `exec_status` bit (level-1) after that edge. It drops `vec_valid` after that edge. Arbitration runs again at the following edge, so a pending vector can reappear two cycles after an acceptance at the earliest.
- R8: A `reti` pulse clears the highest set bit of `exec_status` after the edge. When no bit is set, it has no effect. When it lands in the same cycle as an acceptance, the clear uses the old status and the new bit is then set.
- R9: After reset, `vec_valid` is 0 and `exec_status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N | Request line per source |
| irq_en | input | N | Enable per source |
| glb_en | input | 1 | Global interrupt enable |
| lvl_cfg | input | 2N | Two-bit level code per source |
| lvl_en | input | 3 | Per-level mask (bit0 low, bit1 medium, bit2 high) |
| rr_low | input | 1 | Rotating order for the low level |
| vec_valid | output | 1 | A vector is presented |
| vec_ready | input | 1 | Processor accepts the presented vector |
| vec_idx | output | clog2(N) | Presented source index |
| vec_lvl | output | 2 | Level code of the presented vector |
| reti | input | 1 | Return-from-handler strobe |
| exec_status | output | 3 | Executing flag per level (bit0 low, bit1 medium, bit2 high) |

## Verification
The hardest situations to reach from the ports involve the rotating low level under nesting. One is a low-level pointer that has wrapped past N-1. Another is a return strobe arriving exactly while a higher vector is accepted. The bench keeps several low-level requests raised across repeated acknowledge and return pulses, so the rotation walks and wraps. It stacks low, medium and high handlers and unwinds them one return at a time. A behavioural model, compared every clock, covers the cycles where returns and acceptances happen together.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVLS = 3;

  typedef enum logic [1:0] {
    LVL_NONE = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_MED  = 2'b10,
    LVL_HIGH = 2'b11
  } lvl_e;
endpackage

// File: rtl/irq_lvl_sort.sv
module irq_lvl_sort
  import irq_arb_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]      req,
  input  logic [N-1:0]      en,
  input  logic              glb_en,
  input  logic [2*N-1:0]    cfg,
  input  logic [LVLS-1:0]   lvl_en,
  output logic [N-1:0]      elig_lo,
  output logic [N-1:0]      elig_md,
  output logic [N-1:0]      elig_hi
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic       live;
    logic [1:0] code;
    assign live       = req[i] & en[i] & glb_en;
    assign code       = cfg[2*i +: 2];
    assign elig_lo[i] = live && (code == LVL_LOW)  && lvl_en[0];
    assign elig_md[i] = live && (code == LVL_MED)  && lvl_en[1];
    assign elig_hi[i] = live && (code == LVL_HIGH) && lvl_en[2];
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  input  logic          rr_on,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [N-1:0] above;
  logic [N-1:0] pref;

  for (genvar i = 0; i < N; i++) begin : g_above
    assign above[i] = rr_on && ({1'b0, last} < (IW+1)'(i));
  end

  assign pref = req & above;
  assign any  = |req;

  always_comb begin
    idx = '0;
    if (|pref) begin
      for (int i = N-1; i >= 0; i--) if (pref[i]) idx = IW'(i);
    end else begin
      for (int i = N-1; i >= 0; i--) if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_exec_track.sv
module irq_exec_track
  import irq_arb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  lvl_e            set_lvl,
  input  logic            reti,
  output logic [LVLS-1:0] status,
  output lvl_e            top_lvl
);
  logic [LVLS-1:0] st_q, clr, nxt;

  always_comb begin
    if (st_q[2])      clr = 3'b100;
    else if (st_q[1]) clr = 3'b010;
    else if (st_q[0]) clr = 3'b001;
    else              clr = 3'b000;
    nxt = reti ? (st_q & ~clr) : st_q;
    if (set_en) begin
      case (set_lvl)
        LVL_LOW:  nxt[0] = 1'b1;
        LVL_MED:  nxt[1] = 1'b1;
        LVL_HIGH: nxt[2] = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= nxt;
  end

  assign status  = st_q;
  assign top_lvl = st_q[2] ? LVL_HIGH : st_q[1] ? LVL_MED : st_q[0] ? LVL_LOW : LVL_NONE;
endmodule

// File: rtl/irq_tri_arb.sv
module irq_tri_arb
  import irq_arb_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    irq_req,
  input  logic [N-1:0]    irq_en,
  input  logic            glb_en,
  input  logic [2*N-1:0]  lvl_cfg,
  input  logic [LVLS-1:0] lvl_en,
  input  logic            rr_low,
  output logic            vec_valid,
  input  logic            vec_ready,
  output logic [IW-1:0]   vec_idx,
  output logic [1:0]      vec_lvl,
  input  logic            reti,
  output logic [LVLS-1:0] exec_status
);
  logic [N-1:0]  el_lo, el_md, el_hi;
  logic          any_lo, any_md, any_hi;
  logic [IW-1:0] idx_lo, idx_md, idx_hi;
  logic [IW-1:0] last_lo_q;
  logic          vld_q;
  logic [IW-1:0] idx_q;
  lvl_e          lvl_q;
  lvl_e          exec_top;
  logic          win_any;
  logic [IW-1:0] win_idx;
  lvl_e          win_lvl;
  logic          accept;

  irq_lvl_sort #(.N(N)) u_sort (
    .req(irq_req), .en(irq_en), .glb_en(glb_en), .cfg(lvl_cfg), .lvl_en(lvl_en),
    .elig_lo(el_lo), .elig_md(el_md), .elig_hi(el_hi)
  );

  irq_pick #(.N(N), .IW(IW)) u_pick_hi (
    .req(el_hi), .last(last_lo_q), .rr_on(1'b0), .any(any_hi), .idx(idx_hi));
  irq_pick #(.N(N), .IW(IW)) u_pick_md (
    .req(el_md), .last(last_lo_q), .rr_on(1'b0), .any(any_md), .idx(idx_md));
  irq_pick #(.N(N), .IW(IW)) u_pick_lo (
    .req(el_lo), .last(last_lo_q), .rr_on(rr_low), .any(any_lo), .idx(idx_lo));

  assign accept = vld_q & vec_ready;

  irq_exec_track u_exec (
    .clk(clk), .rst_n(rst_n), .set_en(accept), .set_lvl(lvl_q), .reti(reti),
    .status(exec_status), .top_lvl(exec_top)
  );

  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    win_lvl = LVL_NONE;
    if (any_hi && (exec_top < LVL_HIGH)) begin
      win_any = 1'b1; win_idx = idx_hi; win_lvl = LVL_HIGH;
    end else if (any_md && (exec_top < LVL_MED)) begin
      win_any = 1'b1; win_idx = idx_md; win_lvl = LVL_MED;
    end else if (any_lo && (exec_top == LVL_NONE)) begin
      win_any = 1'b1; win_idx = idx_lo; win_lvl = LVL_LOW;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q     <= 1'b0;
      idx_q     <= '0;
      lvl_q     <= LVL_NONE;
      last_lo_q <= IW'(N-1);
    end else if (!vld_q) begin
      if (win_any) begin
        vld_q <= 1'b1;
        idx_q <= win_idx;
        lvl_q <= win_lvl;
      end
    end else if (vec_ready) begin
      vld_q <= 1'b0;
      if (lvl_q == LVL_LOW) last_lo_q <= idx_q;
    end
  end

  assign vec_valid = vld_q;
  assign vec_idx   = idx_q;
  assign vec_lvl   = lvl_q;
endmodule

// File: rtl/irq_tri_arb_chk.sv
module irq_tri_arb_chk #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vec_valid,
  input logic          vec_ready,
  input logic [IW-1:0] vec_idx,
  input logic [1:0]    vec_lvl,
  input logic          reti,
  input logic [2:0]    exec_status
);
  logic [1:0] top;
  assign top = exec_status[2] ? 2'd3 : exec_status[1] ? 2'd2 : exec_status[0] ? 2'd1 : 2'd0;

  // R6: presented vector is held under back-pressure
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ready |=> vec_valid && $stable(vec_idx) && $stable(vec_lvl));

  // R5: presented level is above every executing level
  a_r5_above_exec: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_lvl > top));

  // R1: a presented vector never carries the none code
  a_r1_lvl_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_lvl != 2'd0));

  // R7: acceptance drops valid and flags the level
  a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_ready |=> !vec_valid);
  a_r7_flag: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_ready |=> ((exec_status & (3'b001 << ($past(vec_lvl) - 2'd1))) != 3'b000));

  // R8: a return clears exactly one flag, or nothing when none is set
  a_r8_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
    reti && !(vec_valid && vec_ready) && (exec_status != 3'b000)
      |=> $countones(exec_status) == $countones($past(exec_status)) - 1);
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    reti && !(vec_valid && vec_ready) && (exec_status == 3'b000) |=> exec_status == 3'b000);
endmodule

bind irq_tri_arb irq_tri_arb_chk #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_ready(vec_ready),
  .vec_idx(vec_idx), .vec_lvl(vec_lvl), .reti(reti), .exec_status(exec_status)
);

// File: tb/irq_tri_arb_bench.sv
module irq_tri_arb_bench;
  localparam int N  = 8;
  localparam int IW = $clog2(N);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    irq_req = '0;
  logic [N-1:0]    irq_en = '0;
  logic            glb_en = 1'b0;
  logic [2*N-1:0]  lvl_cfg = '0;
  logic [2:0]      lvl_en = '0;
  logic            rr_low = 1'b0;
  logic            vec_valid;
  logic            vec_ready = 1'b0;
  logic [IW-1:0]   vec_idx;
  logic [1:0]      vec_lvl;
  logic            reti = 1'b0;
  logic [2:0]      exec_status;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  string cur_req = "R9";

  always #5 clk = ~clk;

  irq_tri_arb #(.N(N)) u_irq_tri_arb (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en), .glb_en(glb_en),
    .lvl_cfg(lvl_cfg), .lvl_en(lvl_en), .rr_low(rr_low), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .vec_idx(vec_idx), .vec_lvl(vec_lvl), .reti(reti),
    .exec_status(exec_status)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int         m_valid, m_idx, m_lvl, m_last;
  logic [2:0] m_st;

  function automatic int top_of(logic [2:0] s);
    if (s[2]) return 3;
    if (s[1]) return 2;
    if (s[0]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_idx = 0; m_lvl = 0; m_last = N-1; m_st = 3'b000;
    end else begin
      logic [2:0] ns;
      int nv, ni, nl;
      bit acc;
      acc = (m_valid == 1) && vec_ready;
      ns = m_st;
      if (reti) begin
        for (int l = 2; l >= 0; l--) if (ns[l]) begin ns[l] = 1'b0; break; end
      end
      if (acc) ns[m_lvl-1] = 1'b1;
      nv = m_valid; ni = m_idx; nl = m_lvl;
      if (acc) begin
        nv = 0;
        if (m_lvl == 1) m_last = m_idx;
      end else if (m_valid == 0) begin
        for (int lv = 3; lv >= 1 && nv == 0; lv--) begin
          if (lv > top_of(m_st) && lvl_en[lv-1] && glb_en) begin
            for (int k = 0; k < N && nv == 0; k++) begin
              int i;
              i = (lv == 1 && rr_low) ? (m_last + 1 + k) % N : k;
              if (irq_req[i] && irq_en[i] && int'(lvl_cfg[2*i +: 2]) == lv) begin
                nv = 1; ni = i; nl = lv;
              end
            end
          end
        end
      end
      m_valid = nv; m_idx = ni; m_lvl = nl; m_st = ns;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(int'(vec_valid) == m_valid, cur_req, "model vec_valid", int'(vec_valid), m_valid);
      check(exec_status == m_st, cur_req, "model exec_status", int'(exec_status), int'(m_st));
      if (m_valid == 1) begin
        check(int'(vec_idx) == m_idx, cur_req, "model vec_idx", int'(vec_idx), m_idx);
        check(int'(vec_lvl) == m_lvl, cur_req, "model vec_lvl", int'(vec_lvl), m_lvl);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic set_lvl(input int i, input int l);
    lvl_cfg[2*i +: 2] = 2'(l);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_valid(input string req);
    for (int k = 0; k < 20 && !vec_valid; k++) @(negedge clk);
    check(vec_valid == 1'b1, req, "vector presented", int'(vec_valid), 1);
  endtask

  task automatic accept_now();
    vec_ready = 1'b1;
    @(negedge clk);
    vec_ready = 1'b0;
  endtask

  task automatic pulse_reti();
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
  endtask

  task automatic expect_vec(input string req, input int idx, input int lvl);
    wait_valid(req);
    check(int'(vec_idx) == idx, req, "vec_idx", int'(vec_idx), idx);
    check(int'(vec_lvl) == lvl, req, "vec_lvl", int'(vec_lvl), lvl);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R9";
    check(vec_valid == 1'b0, "R9", "valid after reset", int'(vec_valid), 0);
    check(exec_status == 3'b000, "R9", "status after reset", int'(exec_status), 0);

    // R4: eligibility gating
    cur_req = "R4";
    set_lvl(1, 2); set_lvl(2, 1); set_lvl(5, 3);
    irq_req = 8'b0010_0110;
    irq_en = 8'hFF; lvl_en = 3'b111;
    idle(4);
    check(vec_valid == 1'b0, "R4", "global enable off", int'(vec_valid), 0);
    glb_en = 1'b1; irq_en = 8'h00;
    idle(4);
    check(vec_valid == 1'b0, "R4", "source enables off", int'(vec_valid), 0);
    irq_en = 8'hFF; lvl_en = 3'b000;
    idle(4);
    check(vec_valid == 1'b0, "R4", "level masks off", int'(vec_valid), 0);
    lvl_en = 3'b111;

    // R1: level ordering, R5 blocking, R7 flag
    cur_req = "R1";
    expect_vec("R1", 5, 3);
    accept_now();
    irq_req[5] = 1'b0;
    check(vec_valid == 1'b0, "R7", "valid drops after accept", int'(vec_valid), 0);
    check(exec_status == 3'b100, "R7", "high flag set", int'(exec_status), 4);
    cur_req = "R5";
    idle(4);
    check(vec_valid == 1'b0, "R5", "medium blocked by high", int'(vec_valid), 0);
    pulse_reti();
    cur_req = "R1";
    expect_vec("R1", 1, 2);
    accept_now();
    irq_req[1] = 1'b0;
    pulse_reti();
    expect_vec("R1", 2, 1);
    accept_now();
    irq_req[2] = 1'b0;
    pulse_reti();

    // R2: static order inside medium
    cur_req = "R2";
    set_lvl(3, 2); set_lvl(6, 2);
    irq_req = 8'b0100_1000;
    expect_vec("R2", 3, 2);
    accept_now();
    irq_req[3] = 1'b0;
    pulse_reti();
    expect_vec("R2", 6, 2);
    accept_now();
    irq_req[6] = 1'b0;
    pulse_reti();

    // R3: low-level rotation
    cur_req = "R3";
    set_lvl(1, 1); set_lvl(4, 1); set_lvl(6, 1);
    irq_req = 8'b0101_0010;
    expect_vec("R2", 1, 1);
    accept_now();
    rr_low = 1'b1;
    pulse_reti();
    expect_vec("R3", 4, 1);
    accept_now(); pulse_reti();
    expect_vec("R3", 6, 1);
    accept_now(); pulse_reti();
    expect_vec("R3", 1, 1);
    accept_now(); pulse_reti();
    expect_vec("R3", 4, 1);
    accept_now();
    irq_req = 8'b0000_0000;
    pulse_reti();

    // R6: hold under back-pressure
    cur_req = "R6";
    irq_req[4] = 1'b1;
    expect_vec("R6", 4, 1);
    irq_req[4] = 1'b0;
    irq_req[5] = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(vec_valid == 1'b1 && int'(vec_idx) == 4 && vec_lvl == 2'd1,
            "R6", "held vector idx", int'(vec_idx), 4);
    end
    accept_now();
    cur_req = "R7";
    check(vec_valid == 1'b0, "R7", "gap cycle after accept", int'(vec_valid), 0);
    @(negedge clk);
    check(vec_valid == 1'b1 && int'(vec_idx) == 5, "R7", "re-presented high idx", int'(vec_idx), 5);
    accept_now();
    irq_req[5] = 1'b0;
    check(exec_status == 3'b101, "R7", "nested status", int'(exec_status), 5);

    // R8: nesting and unwinding
    cur_req = "R8";
    irq_req[3] = 1'b1;
    idle(3);
    check(vec_valid == 1'b0, "R5", "medium blocked under high", int'(vec_valid), 0);
    pulse_reti();
    check(exec_status == 3'b001, "R8", "high cleared first", int'(exec_status), 1);
    expect_vec("R8", 3, 2);
    accept_now();
    irq_req[3] = 1'b0;
    irq_req[5] = 1'b1;
    expect_vec("R8", 5, 3);
    accept_now();
    irq_req[5] = 1'b0;
    check(exec_status == 3'b111, "R8", "all levels executing", int'(exec_status), 7);
    pulse_reti();
    check(exec_status == 3'b011, "R8", "unwind high", int'(exec_status), 3);
    pulse_reti();
    check(exec_status == 3'b001, "R8", "unwind medium", int'(exec_status), 1);
    pulse_reti();
    check(exec_status == 3'b000, "R8", "unwind low", int'(exec_status), 0);
    pulse_reti();
    check(exec_status == 3'b000, "R8", "return with nothing executing", int'(exec_status), 0);
    idle(3);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule